// File: doc/BRIEF.md
# Pipelined Local-Bus Cycle Sequencer

This block is the bus-master side of a processor-style local bus. An internal requester presents one cycle at a time: an address plus write, memory-or-I/O, 8-bit-device and lock attributes, held steady until the sequencer accepts it. The sequencer drives the address and status lines, pulses an active-low address strobe when it issues a cycle, and samples two active-low inputs from the addressed device. The first is a ready input that ends the data phase of the current cycle. The second is a next-address input that lets the following cycle's address go out while the current data phase is still running.

The machine has five states. IDLE is the bus-idle state. ISSUE is the first clock of a cycle that is not overlapped: the strobe is low and the request's address is on the bus. DATA is every later clock of a cycle, and it inserts wait states while ready is high. OVERLAP is a data clock of the current cycle in which the next cycle's address is issued with the strobe. HOLD_NEXT is a later data clock of the current cycle, entered when ready was still high in OVERLAP, and it keeps the already-issued next address on the bus. The transitions are: IDLE to ISSUE on a permitted request. ISSUE to DATA always. DATA to DATA while ready is high. DATA to OVERLAP when next-address is low in an eligible memory cycle and a permitted request waits. DATA to ISSUE or to IDLE when ready is low, depending on whether a permitted request waits. OVERLAP to DATA when ready is low, or to HOLD_NEXT when it is high. HOLD_NEXT to DATA when ready is low. Reset leads to IDLE from any state.

Locked cycles come in fixed-length groups of `LOCK_LEN` cycles, two for a read-modify-write pair. The lock output covers a group from the clock in which its first cycle is issued to the ready that ends its last cycle. While the lock output is low, the sequencer issues only the remaining locked cycles of the group.

Top module: `lbus_cycle_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `bus_strobe_n`=1, `req_accept`=0, `bus_lock_n`=1 and `cyc_done`=0, whatever `ready_n` and `next_n` do.
- R2: From idle, a valid permitted request causes no strobe in the clock it first appears. In the next clock `bus_strobe_n`=0 and `req_accept`=1, and the bus shows the request's address, `bus_write`, `bus_mem` (1 = memory, 0 = I/O) and `bus_narrow` (1 = 8-bit device) in that same clock.
- R3: The issue clock lasts exactly one clock and is followed by a data clock. A low `ready_n` during the issue clock is ignored and gives no `cyc_done`.
- R4: In a data clock, `ready_n`=1 inserts a wait state. The strobe stays high and the address and status hold.
- R5: In a data clock, `ready_n`=0 ends the cycle with `cyc_done`=1 in that clock. The next clock is an issue clock if a permitted request is waiting, and idle otherwise. Cycles that are not overlapped therefore take at least two clocks.
- R6: If `next_n`=0 in a data clock of a memory cycle that is not an 8-bit-device cycle, and a permitted request waits, and `ready_n`=1, then the next clock strobes and accepts the waiting request with its address on the bus. The earlier cycle still ends on its own ready. The new address holds until that ready, and the clock after it is already a data clock of the new cycle, with no issue clock of its own.
- R7: `next_n` has no effect during I/O cycles (`req_mem`=0) or 8-bit-device cycles (`req_narrow`=1). No strobe appears before that cycle's ready.
- R8: For a group of `LOCK_LEN` requests, all with `req_lock`=1, `bus_lock_n` is 0 from the issue clock of the first cycle through the clock where ready ends the last cycle, and 1 in the clock after.
- R9: While `bus_lock_n` is 0, a request with `req_lock`=0 is neither accepted nor overlapped, even when `next_n` is low. It is accepted once the lock has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held with stable fields until accepted |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_narrow | input | 1 | 1 = cycle to an 8-bit device |
| req_lock | input | 1 | Request belongs to a locked group |
| req_accept | output | 1 | High in the clock the request's address is first driven |
| ready_n | input | 1 | Active-low end of the current data phase |
| next_n | input | 1 | Active-low request to issue the next address early |
| bus_addr | output | AW | Address on the bus |
| bus_write | output | 1 | Write status on the bus |
| bus_mem | output | 1 | Memory/I-O status on the bus |
| bus_narrow | output | 1 | 8-bit-device status on the bus |
| bus_strobe_n | output | 1 | Active-low address strobe |
| bus_lock_n | output | 1 | Active-low bus lock |
| cyc_done | output | 1 | High in the clock ready ends a cycle |

## Verification
The bench builds the block with `AW`=8 and `LOCK_LEN`=2. This is small enough to sweep every pairing of the first cycle's kind (memory, I/O, 8-bit device), zero to three wait states, next-address held low or high, and zero to two wait states on the second cycle. The sweep reaches the overlap with and without extra waits and the ready-before-overlap race. A two-cycle locked pair with an intruding unlocked request reaches both the lock-blocking path and the release timing.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DATA,
        ST_OVERLAP,
        ST_HOLD_NEXT
    } bus_state_e;

    typedef enum logic [1:0] {
        SRC_REQ,
        SRC_CUR,
        SRC_NXT
    } bus_src_e;

    typedef struct packed {
        logic wr;
        logic mem;
        logic narrow;
        logic last;
    } cyc_attr_t;

endpackage

// File: rtl/lbus_seq_fsm.sv
module lbus_seq_fsm
    import lbus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       pipe_ok,
    input  logic       ready_n,
    input  logic       next_n,
    output bus_state_e state_o,
    output logic       issue,
    output logic       done,
    output bus_src_e   src,
    output logic       ld_cur_req,
    output logic       ld_nxt_req,
    output logic       ld_cur_nxt
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go) state_d = ST_ISSUE;
            ST_ISSUE:     state_d = ST_DATA;
            ST_DATA: begin
                if (!ready_n)                      state_d = go ? ST_ISSUE : ST_IDLE;
                else if (!next_n && pipe_ok && go) state_d = ST_OVERLAP;
            end
            ST_OVERLAP:   state_d = ready_n ? ST_HOLD_NEXT : ST_DATA;
            ST_HOLD_NEXT: if (!ready_n) state_d = ST_DATA;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        issue      = 1'b0;
        done       = 1'b0;
        src        = SRC_CUR;
        ld_cur_req = 1'b0;
        ld_nxt_req = 1'b0;
        ld_cur_nxt = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                issue      = 1'b1;
                src        = SRC_REQ;
                ld_cur_req = 1'b1;
            end
            ST_DATA: done = !ready_n;
            ST_OVERLAP: begin
                issue      = 1'b1;
                src        = SRC_REQ;
                done       = !ready_n;
                ld_cur_req = !ready_n;
                ld_nxt_req = ready_n;
            end
            ST_HOLD_NEXT: begin
                src        = SRC_NXT;
                done       = !ready_n;
                ld_cur_nxt = !ready_n;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R3: the issue clock is always followed by a data clock
    p_issue_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE) |=> (state_q == ST_DATA));

    // R4: a high ready with no early-address request keeps the cycle waiting
    p_wait_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && ready_n && next_n) |=> (state_q == ST_DATA));

    // R5: a cycle ended with nothing permitted waiting returns to idle
    p_end_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !ready_n && !go) |=> (state_q == ST_IDLE));

    // R7: no overlap out of an ineligible cycle
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !pipe_ok) |=> (state_q != ST_OVERLAP));

endmodule

// File: rtl/lbus_seq_lock.sv
module lbus_seq_lock #(
    parameter int LOCK_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_lock,
    input  logic issue,
    input  logic done,
    input  logic done_last,
    output logic permit,
    output logic last_in,
    output logic lock_out
);

    localparam int CW = $clog2(LOCK_LEN + 1);

    logic          lock_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else if (done && done_last) begin
            lock_q <= 1'b0;
            cnt_q  <= '0;
        end else if (issue && req_lock) begin
            lock_q <= 1'b1;
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign permit   = !lock_q || (req_lock && (cnt_q < CW'(LOCK_LEN)));
    assign last_in  = req_lock && (cnt_q == CW'(LOCK_LEN - 1));
    assign lock_out = lock_q || (issue && req_lock);

    // R9: while the lock is held only locked requests are issued
    p_lock_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && issue) |-> req_lock);

    // R8: no more cycles are issued in a group than its length
    p_group_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LOCK_LEN));

endmodule

// File: rtl/lbus_seq_hold.sv
module lbus_seq_hold
    import lbus_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] req_addr,
    input  cyc_attr_t     req_attr,
    input  bus_src_e      src,
    input  logic          ld_cur_req,
    input  logic          ld_nxt_req,
    input  logic          ld_cur_nxt,
    output logic [AW-1:0] out_addr,
    output logic          out_wr,
    output logic          out_mem,
    output logic          out_narrow,
    output logic          cur_pipe_ok,
    output logic          cur_last
);

    logic [AW-1:0] cur_addr_q, nxt_addr_q;
    cyc_attr_t     cur_attr_q, nxt_attr_q, sel_attr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            cur_attr_q <= '0;
            nxt_addr_q <= '0;
            nxt_attr_q <= '0;
        end else begin
            if (ld_cur_req) begin
                cur_addr_q <= req_addr;
                cur_attr_q <= req_attr;
            end else if (ld_cur_nxt) begin
                cur_addr_q <= nxt_addr_q;
                cur_attr_q <= nxt_attr_q;
            end
            if (ld_nxt_req) begin
                nxt_addr_q <= req_addr;
                nxt_attr_q <= req_attr;
            end
        end
    end

    always_comb begin
        unique case (src)
            SRC_REQ: begin
                out_addr = req_addr;
                sel_attr = req_attr;
            end
            SRC_NXT: begin
                out_addr = nxt_addr_q;
                sel_attr = nxt_attr_q;
            end
            default: begin
                out_addr = cur_addr_q;
                sel_attr = cur_attr_q;
            end
        endcase
    end

    assign out_wr      = sel_attr.wr;
    assign out_mem     = sel_attr.mem;
    assign out_narrow  = sel_attr.narrow;
    assign cur_pipe_ok = cur_attr_q.mem && !cur_attr_q.narrow;
    assign cur_last    = cur_attr_q.last;

endmodule

// File: rtl/lbus_cycle_seq.sv
module lbus_cycle_seq
    import lbus_seq_pkg::*;
#(
    parameter int AW       = 8,
    parameter int LOCK_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_mem,
    input  logic          req_narrow,
    input  logic          req_lock,
    output logic          req_accept,
    input  logic          ready_n,
    input  logic          next_n,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic          bus_mem,
    output logic          bus_narrow,
    output logic          bus_strobe_n,
    output logic          bus_lock_n,
    output logic          cyc_done
);

    bus_state_e fsm_state;
    bus_src_e   src;
    cyc_attr_t  req_attr;
    logic       issue, done, permit, last_in, lock_out;
    logic       pipe_ok, cur_last;
    logic       ld_cur_req, ld_nxt_req, ld_cur_nxt;

    assign req_attr = '{wr: req_write, mem: req_mem, narrow: req_narrow, last: last_in};

    lbus_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (req_valid && permit),
        .pipe_ok    (pipe_ok),
        .ready_n    (ready_n),
        .next_n     (next_n),
        .state_o    (fsm_state),
        .issue      (issue),
        .done       (done),
        .src        (src),
        .ld_cur_req (ld_cur_req),
        .ld_nxt_req (ld_nxt_req),
        .ld_cur_nxt (ld_cur_nxt)
    );

    lbus_seq_lock #(.LOCK_LEN(LOCK_LEN)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_lock  (req_lock),
        .issue     (issue),
        .done      (done),
        .done_last (cur_last),
        .permit    (permit),
        .last_in   (last_in),
        .lock_out  (lock_out)
    );

    lbus_seq_hold #(.AW(AW)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_addr    (req_addr),
        .req_attr    (req_attr),
        .src         (src),
        .ld_cur_req  (ld_cur_req),
        .ld_nxt_req  (ld_nxt_req),
        .ld_cur_nxt  (ld_cur_nxt),
        .out_addr    (bus_addr),
        .out_wr      (bus_write),
        .out_mem     (bus_mem),
        .out_narrow  (bus_narrow),
        .cur_pipe_ok (pipe_ok),
        .cur_last    (cur_last)
    );

    assign req_accept   = issue;
    assign bus_strobe_n = !issue;
    assign bus_lock_n   = !lock_out;
    assign cyc_done     = done;

    // R4: address holds across a wait state of a plain data clock
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DATA && ready_n && next_n) |=> $stable(bus_addr));

    // R6: an early-issued address holds until the running cycle ends
    p_next_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_OVERLAP && ready_n) |=> $stable(bus_addr));

    // R2: a strobe always comes with an accepted request
    p_strobe_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe_n |-> req_valid);

endmodule

// File: tb/lbus_cycle_seq_bench.sv
module lbus_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write, req_mem, req_narrow, req_lock;
    logic [AW-1:0] req_addr;
    logic          req_accept, ready_n, next_n;
    logic [AW-1:0] bus_addr;
    logic          bus_write, bus_mem, bus_narrow, bus_strobe_n, bus_lock_n, cyc_done;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbus_cycle_seq #(.AW(AW), .LOCK_LEN(2)) u_lbus_cycle_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_mem      (req_mem),
        .req_narrow   (req_narrow),
        .req_lock     (req_lock),
        .req_accept   (req_accept),
        .ready_n      (ready_n),
        .next_n       (next_n),
        .bus_addr     (bus_addr),
        .bus_write    (bus_write),
        .bus_mem      (bus_mem),
        .bus_narrow   (bus_narrow),
        .bus_strobe_n (bus_strobe_n),
        .bus_lock_n   (bus_lock_n),
        .cyc_done     (cyc_done)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [AW-1:0] a, input logic w,
                         input logic m, input logic nar, input logic lk);
        req_valid  = v;
        req_addr   = a;
        req_write  = w;
        req_mem    = m;
        req_narrow = nar;
        req_lock   = lk;
    endtask

    // One cycle A of kind ka (0 memory, 1 I/O, 2 8-bit device) with w1 waits,
    // next_n low during its data clocks when na, then memory cycle B with w2 waits.
    task automatic run_pair(input int ka, input int w1, input bit na, input int w2);
        logic [AW-1:0] a_addr, b_addr;
        logic          a_mem, a_nar, a_wr;
        bit            pipe, b_taken;
        string         tag;
        a_addr  = AW'(ka * 16 + w1 * 4 + int'(na) * 2 + w2 + 64);
        b_addr  = a_addr ^ AW'(8'hA5);
        a_mem   = (ka != 1);
        a_nar   = (ka == 2);
        a_wr    = w1[0];
        pipe    = na && a_mem && !a_nar && (w1 >= 1);
        tag     = pipe ? "R6" : ((na && (ka != 0)) ? "R7" : "R4");
        b_taken = 0;

        @(negedge clk);
        drive(1'b1, a_addr, a_wr, a_mem, a_nar, 1'b0);
        ready_n = 1'b1; next_n = 1'b1;
        #1;
        check("R2 no strobe on first idle clock", bus_strobe_n, 1);
        check("R2 no accept on first idle clock", req_accept, 0);

        @(negedge clk); #1;
        check("R2 issue strobe", bus_strobe_n, 0);
        check("R2 issue accept", req_accept, 1);
        check("R2 issue address", bus_addr, a_addr);
        check("R2 issue write", bus_write, a_wr);
        check("R2 issue mem", bus_mem, a_mem);
        check("R2 issue narrow", bus_narrow, a_nar);

        for (int j = 0; j <= w1; j++) begin
            @(negedge clk);
            drive(!b_taken, b_addr, 1'b1, 1'b1, 1'b0, 1'b0);
            ready_n = (j != w1);
            next_n  = !na;
            #1;
            check({tag, " strobe in first cycle data clock"}, bus_strobe_n, !(pipe && j == 1));
            check({tag, " accept in first cycle data clock"}, req_accept, pipe && j == 1);
            check({tag, " done in first cycle data clock"}, cyc_done, j == w1);
            check({tag, " address in first cycle data clock"}, bus_addr,
                  (pipe && j >= 1) ? b_addr : a_addr);
            if (pipe && j == 1) b_taken = 1;
        end

        if (!pipe) begin
            @(negedge clk);
            drive(1'b1, b_addr, 1'b1, 1'b1, 1'b0, 1'b0);
            ready_n = 1'b0; next_n = 1'b1;
            #1;
            check("R5 follow-on issue strobe", bus_strobe_n, 0);
            check("R5 follow-on accept", req_accept, 1);
            check("R5 follow-on address", bus_addr, b_addr);
            check("R3 ready ignored in issue clock", cyc_done, 0);
        end

        for (int k = 0; k <= w2; k++) begin
            @(negedge clk);
            drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
            ready_n = (k != w2); next_n = 1'b1;
            #1;
            check(pipe ? "R6 second cycle without issue clock" : "R4 second cycle wait",
                  bus_strobe_n, 1);
            check("R4 second cycle address", bus_addr, b_addr);
            check("R4 second cycle write", bus_write, 1);
            check("R5 second cycle done", cyc_done, k == w2);
        end

        @(negedge clk);
        ready_n = 1'b1;
        #1;
        check("R5 idle after last cycle", bus_strobe_n, 1);
        check("R5 no done in idle", cyc_done, 0);
    endtask

    task automatic run_lock();
        @(negedge clk);
        drive(1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1);
        ready_n = 1'b1; next_n = 1'b1;
        #1;
        check("R8 lock high before group", bus_lock_n, 1);
        @(negedge clk); #1;
        check("R8 lock low from first issue", bus_lock_n, 0);
        check("R8 first locked accept", req_accept, 1);

        @(negedge clk);
        drive(1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
        next_n = 1'b0;
        #1;
        check("R9 unlocked request not overlapped", bus_strobe_n, 1);
        check("R8 lock held in first data clock", bus_lock_n, 0);
        @(negedge clk);
        ready_n = 1'b0;
        #1;
        check("R8 first locked cycle done", cyc_done, 1);
        check("R9 no accept at first locked done", req_accept, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ready_n = 1'b1; next_n = 1'b1;
            #1;
            check("R9 unlocked request held off", req_accept, 0);
            check("R8 lock held between group cycles", bus_lock_n, 0);
        end

        @(negedge clk);
        drive(1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 1'b1);
        #1;
        check("R2 idle clock before second locked issue", req_accept, 0);
        @(negedge clk); #1;
        check("R8 second locked accept", req_accept, 1);
        check("R8 second locked address", bus_addr, 8'h33);
        check("R8 lock low in second issue", bus_lock_n, 0);

        @(negedge clk);
        drive(1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
        ready_n = 1'b0;
        #1;
        check("R8 second locked done", cyc_done, 1);
        check("R8 lock low in last done clock", bus_lock_n, 0);
        @(negedge clk);
        ready_n = 1'b1;
        #1;
        check("R8 lock released after last done", bus_lock_n, 1);
        check("R9 no accept in release clock", req_accept, 0);
        @(negedge clk); #1;
        check("R9 unlocked accept after release", req_accept, 1);
        check("R9 unlocked address after release", bus_addr, 8'h22);
        check("R9 lock stays high for unlocked", bus_lock_n, 1);
        @(negedge clk);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        ready_n = 1'b0;
        #1;
        check("R5 unlocked cycle done", cyc_done, 1);
        @(negedge clk);
        ready_n = 1'b1;
        #1;
        check("R5 idle at end", bus_strobe_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);
        ready_n = 1'b0; next_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check("R1 strobe high in reset", bus_strobe_n, 1);
            check("R1 accept low in reset", req_accept, 0);
            check("R1 lock high in reset", bus_lock_n, 1);
            check("R1 done low in reset", cyc_done, 0);
        end
        @(negedge clk);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #1;
            check("R1 idle after reset strobe", bus_strobe_n, 1);
            check("R1 idle after reset done", cyc_done, 0);
        end
        ready_n = 1'b1; next_n = 1'b1;

        for (int ka = 0; ka < 3; ka++)
            for (int w1 = 0; w1 <= 3; w1++)
                for (int na = 0; na < 2; na++)
                    for (int w2 = 0; w2 <= 2; w2++)
                        run_pair(ka, w1, na[0], w2);

        run_lock();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule